// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits between a set of interrupting devices and a processor. Each device owns one request line, numbered from level 1 upward. Level 1 is the most urgent. The controller keeps a pending flag per level. When the processor signals that it can take an interrupt, the controller picks the most urgent eligible pending level. It then publishes that level once as a binary code on a shared acknowledge bus, qualified by a one-cycle valid strobe. Code 0 stands for "no grant". A per-device decode of the bus tells each device whether the grant was its own.

The controller remembers every level it has granted and not yet closed. This set of levels is always strictly nested, so the most urgent one is the level in service. A new grant must be strictly more urgent than the level in service. Requests at the same level or a less urgent level wait in their pending flags. An end-of-service pulse closes the current level and returns to the one it interrupted. A parameter selects how requests are captured:

- rising-edge capture (the default), or
- level-sensitive capture, where the device drops its line after seeing its grant.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, ack_valid_o is 0, ack_code_o is 0 and dev_grant_o is all zeros. Reset also empties the in-service set. Because of this, a level granted before reset does not mask requests after reset.
- R2: In edge mode, a rising edge on req_i[k] sets the pending flag of level k+1 at that clock edge. The flag stays set until that level is granted. A line that stays high after its grant does not raise a second request.
- R3: A grant appears on the outputs only at the clock edge that samples cpu_ready_i high. While cpu_ready_i is low, pending levels stay pending.
- R4: When several eligible levels are pending, the lowest-numbered level wins.
- R5: On a grant, ack_valid_o is 1 for that cycle and ack_code_o carries the winning level as an unsigned binary number from 1 to N_LEVELS. In every cycle without a grant, ack_code_o is 0.
- R6: dev_grant_o[k] is 1 exactly when ack_valid_o is 1 and ack_code_o equals k+1.
- R7: A pending level is granted only if it is strictly lower-numbered than the level in service, or if nothing is in service. Levels equal to or higher-numbered than the level in service remain pending.
- R8: A grant pushes its level into the in-service set. Each eos_i pulse removes the level in service, so the level it preempted becomes current again.
- R9: A grant decision made in the same cycle as an eos_i pulse is judged against the level in service before that pulse.
- R10: eos_i with nothing in service has no effect on later grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_LEVELS | Request lines; bit k is level k+1 |
| cpu_ready_i | input | 1 | Processor can take an interrupt this cycle |
| eos_i | input | 1 | End of service for the level in service |
| ack_valid_o | output | 1 | One-cycle strobe qualifying ack_code_o |
| ack_code_o | output | $clog2(N_LEVELS+1) | Binary code of the granted level, 0 when idle |
| dev_grant_o | output | N_LEVELS | Per-device decode of the acknowledge bus |

## Verification
The properties assume that eos_i is pulsed only while a level is actually in service. They also assume that devices drive clean synchronous request levels. From these assumptions they conclude that every grant is strictly more urgent than the previously current level and appears in the in-service set. The stimulus pulses end-of-service exactly once per outstanding grant, except for one deliberate idle pulse that the R10 case covers. Inputs change only on the falling clock edge, away from the sampling edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // How request lines become pending flags.
   typedef enum logic {
      REQ_EDGE  = 1'b0,
      REQ_LEVEL = 1'b1
   } req_mode_e;
endpackage

// File: rtl/prio_irq_pick.sv
// Finds the lowest set bit of a vector: one-hot form plus 1-based binary code.
module prio_irq_pick #(
   parameter int W      = 7,
   parameter int CODE_W = 3
) (
   input  logic [W-1:0]      vec_i,
   output logic [W-1:0]      oh_o,
   output logic [CODE_W-1:0] code_o,
   output logic              any_o
);
   always_comb begin
      oh_o   = vec_i & (~vec_i + W'(1));
      code_o = '0;
      for (int i = 0; i < W; i++) begin
         if (oh_o[i]) code_o = CODE_W'(i + 1);
      end
   end

   assign any_o = |vec_i;
endmodule

// File: rtl/prio_irq_capture.sv
// Turns request lines into pending flags; the variant is picked by MODE.
module prio_irq_capture
   import prio_irq_pkg::*;
#(
   parameter int        W    = 7,
   parameter req_mode_e MODE = REQ_EDGE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);
   generate
      if (MODE == REQ_EDGE) begin : g_edge
         logic [W-1:0] req_q;
         logic [W-1:0] pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q  <= '0;
               pend_q <= '0;
            end else begin
               req_q  <= req_i;
               pend_q <= (pend_q & ~clr_i) | (req_i & ~req_q);
            end
         end
         assign pend_o = pend_q;
      end else begin : g_level
         // Block a level in the cycle its grant is shown, while the device drops its line.
         logic [W-1:0] blk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) blk_q <= '0;
            else        blk_q <= clr_i;
         end
         assign pend_o = req_i & ~blk_q;
      end
   endgenerate
endmodule

// File: rtl/prio_irq_inservice.sv
// Set of granted-but-unfinished levels; strictly nested, so a bit mask suffices.
module prio_irq_inservice #(
   parameter int W      = 7,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      push_i,
   input  logic              eos_i,
   output logic [W-1:0]      isr_o,
   output logic [CODE_W-1:0] cur_code_o,
   output logic [W-1:0]      allow_o
);
   logic [W-1:0] isr_q;
   logic [W-1:0] cur_oh;
   logic         busy;

   prio_irq_pick #(.W(W), .CODE_W(CODE_W)) u_cur (
      .vec_i  (isr_q),
      .oh_o   (cur_oh),
      .code_o (cur_code_o),
      .any_o  (busy)
   );

   // Only levels strictly more urgent than the current one may be granted.
   assign allow_o = busy ? (cur_oh - W'(1)) : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~(eos_i ? cur_oh : '0)) | push_i;
   end

   assign isr_o = isr_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int        N_LEVELS = 7,
   parameter req_mode_e REQ_MODE = REQ_EDGE,
   localparam int       CODE_W   = $clog2(N_LEVELS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] req_i,
   input  logic                cpu_ready_i,
   input  logic                eos_i,
   output logic                ack_valid_o,
   output logic [CODE_W-1:0]   ack_code_o,
   output logic [N_LEVELS-1:0] dev_grant_o
);
   generate
      if (N_LEVELS < 2 || N_LEVELS > 255) begin : g_bad_levels
         $error("prio_irq_ctrl: N_LEVELS must lie in 2..255");
      end
   endgenerate

   logic [N_LEVELS-1:0] pend;
   logic [N_LEVELS-1:0] allow;
   logic [N_LEVELS-1:0] win_oh;
   logic [CODE_W-1:0]   win_code;
   logic                win_any;
   logic                grant_now;
   logic [N_LEVELS-1:0] push;
   logic [N_LEVELS-1:0] isr_vec;
   logic [CODE_W-1:0]   cur_code;

   prio_irq_capture #(.W(N_LEVELS), .MODE(REQ_MODE)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .clr_i  (push),
      .pend_o (pend)
   );

   prio_irq_pick #(.W(N_LEVELS), .CODE_W(CODE_W)) u_win (
      .vec_i  (pend & allow),
      .oh_o   (win_oh),
      .code_o (win_code),
      .any_o  (win_any)
   );

   assign grant_now = cpu_ready_i & win_any;
   assign push      = grant_now ? win_oh : '0;

   prio_irq_inservice #(.W(N_LEVELS), .CODE_W(CODE_W)) u_isr (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .eos_i      (eos_i),
      .isr_o      (isr_vec),
      .cur_code_o (cur_code),
      .allow_o    (allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid_o <= 1'b0;
         ack_code_o  <= '0;
      end else begin
         ack_valid_o <= grant_now;
         ack_code_o  <= grant_now ? win_code : '0;
      end
   end

   // Each device compares the shared code with its own level number.
   generate
      for (genvar k = 0; k < N_LEVELS; k++) begin : g_dev
         assign dev_grant_o[k] = ack_valid_o && (ack_code_o == CODE_W'(k + 1));
      end
   endgenerate
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int  N_LEVELS = 7,
   localparam int CODE_W   = $clog2(N_LEVELS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_ready,
   input logic                ack_valid,
   input logic [CODE_W-1:0]   ack_code,
   input logic [N_LEVELS-1:0] dev_grant,
   input logic [N_LEVELS-1:0] isr,
   input logic [CODE_W-1:0]   cur_code
);
   p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_valid |-> ack_code == '0);

   p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (ack_code != '0) && (ack_code <= CODE_W'(N_LEVELS)));

   p_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_grant) && ((|dev_grant) == ack_valid));

   p_ready_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(cpu_ready));

   p_preempt_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(cur_code) == '0) || (ack_code < $past(cur_code)));

   p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> isr[ack_code - CODE_W'(1)]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_LEVELS(N_LEVELS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready_i),
   .ack_valid (ack_valid_o),
   .ack_code  (ack_code_o),
   .dev_grant (dev_grant_o),
   .isr       (isr_vec),
   .cur_code  (cur_code)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
   localparam int N  = 7;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          rdy = 1'b0;
   logic          eos = 1'b0;
   logic          ack_valid;
   logic [CW-1:0] ack_code;
   logic [N-1:0]  dev_grant;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   prio_irq_ctrl #(.N_LEVELS(N)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .cpu_ready_i (rdy),
      .eos_i       (eos),
      .ack_valid_o (ack_valid),
      .ack_code_o  (ack_code),
      .dev_grant_o (dev_grant)
   );

   // Row layout: {req[6:0], cpu_ready, eos, expected valid, expected code[2:0]}.
   localparam int NV = 25;
   localparam logic [12:0] VEC [NV] = '{
      13'b0000000_1_0_0_000,
      13'b0000100_0_0_0_000,
      13'b0000100_0_0_0_000,
      13'b0000100_1_0_1_011,
      13'b0010100_1_0_0_000,
      13'b0010100_1_0_0_000,
      13'b0010101_1_0_0_000,
      13'b0010101_1_0_1_001,
      13'b0010101_1_1_0_000,
      13'b0010101_1_1_0_000,
      13'b0010101_1_0_1_101,
      13'b0000000_1_0_0_000,
      13'b0010000_1_0_0_000,
      13'b0010000_1_0_0_000,
      13'b0010000_1_1_0_000,
      13'b0010000_1_0_1_101,
      13'b0000000_1_1_0_000,
      13'b1001010_1_0_0_000,
      13'b1001010_1_0_1_010,
      13'b1001010_1_1_0_000,
      13'b1001010_1_0_1_100,
      13'b1001010_1_1_0_000,
      13'b1001010_1_0_1_111,
      13'b0000000_1_1_0_000,
      13'b0000000_1_0_0_000
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_ack(input string tag, input int v, input int code);
      int exp_g;
      exp_g = (v != 0) ? (1 << (code - 1)) : 0;
      check({tag, " valid"}, int'(ack_valid), v);
      check({tag, " code"}, int'(ack_code), code);
      check({tag, " R6 decode"}, int'(dev_grant), exp_g);
   endtask

   initial begin
      // R1: outputs are quiet during reset.
      @(negedge clk);
      check_ack("R1 in reset", 0, 0);
      step();
      rst_n = 1'b1;
      step();
      check_ack("R1 after release", 0, 0);

      // Vector walk: R2 R3 R4 R5 R7 R8 R9 under mixed patterns.
      for (int i = 0; i < NV; i++) begin
         req = VEC[i][12:6];
         rdy = VEC[i][5];
         eos = VEC[i][4];
         step();
         check_ack($sformatf("R2 R3 R4 R5 R7 R8 R9 row %0d", i),
                   int'(VEC[i][3]), int'(VEC[i][2:0]));
      end
      eos = 1'b0;
      req = '0;

      // R10: end-of-service while idle changes nothing.
      eos = 1'b1;
      step();
      eos = 1'b0;
      req = 7'b0100000;
      step();
      step();
      check_ack("R10 grant after idle eos", 1, 6);

      // R2: a line held high is a single request.
      eos = 1'b1;
      step();
      eos = 1'b0;
      check_ack("R2 held line no regrant a", 0, 0);
      for (int j = 0; j < 3; j++) begin
         step();
         check_ack("R2 held line no regrant b", 0, 0);
      end

      // R1: reset during service empties the in-service set.
      req = '0;
      step();
      req = 7'b0100000;
      step();
      step();
      check_ack("R1 setup grant", 1, 6);
      req = '0;
      rst_n = 1'b0;
      step();
      check_ack("R1 mid reset", 0, 0);
      rst_n = 1'b1;
      req = 7'b1000000;
      step();
      step();
      check_ack("R1 service cleared by reset", 1, 7);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule